// File: doc/BRIEF.md
# Mealy State Equivalence Engine

This engine finds which states of a small, completely specified Mealy machine behave identically. The machine has up to eight states, a one-bit input and a one-bit output. Software or a neighbouring block fills the transition table through a write port. Each write supplies a state index, an input value, a next state and an output bit. A one-cycle start pulse then launches the computation.

The engine begins with every valid state in one group and refines that grouping once per clock cycle. The first pass separates states whose output bits differ. Every later pass separates states whose successors fell into different groups on the previous pass. When a pass changes nothing, the engine stops and raises done. It then reports a group label for every state and the number of passes it ran. A group's label is the smallest state index it contains, so two equivalent states always carry the same number.

Top module: `fsm_equiv_engine`

## Requirements
- R1: A write with `wr_en` high, made while the engine is not busy, stores `wr_next` and `wr_out` as the transition of state `wr_state` under input value `wr_input`. Input value 0 and input value 1 each have their own entry.
- R2: A `start` pulse while idle or done makes `busy` high on the next cycle. `busy` stays high until the run converges. On the cycle after the last pass, `busy` goes low and `done` goes high. Out of reset, `busy`, `done`, `pass_count` and all labels are 0.
- R3: The run starts from one group that holds every valid state. Pass 1 separates two states when, for input 0 or for input 1, their output bits differ.
- R4: Every pass after the first separates two states of the same group when, for input 0 or for input 1, their next states lie in different groups of the previous pass.
- R5: The run ends after the first pass that leaves the grouping unchanged. `pass_count` then equals the number of passes run, counting that final pass.
- R6: When done, the label of each valid state is the lowest state index in its group. State `s` is read from `class_ids[3*s+2 : 3*s]`.
- R7: `pass_count` never exceeds the number of states. A table that needs eight passes reports eight.
- R8: A write made while `busy` is high changes nothing in the table.
- R9: A `start` pulse while `busy` is high is ignored. The run continues and its pass count is unchanged.
- R10: `num_valid`, sampled at start, gives how many states take part, from 1 to 8. A value of 0 is treated as 1 and values above 8 as 8. States with an index at or above this count report label 0.
- R11: `done` and all labels hold their values until the next `start`. On the cycle after that `start`, `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe |
| wr_state | input | 3 | State whose transition is written |
| wr_input | input | 1 | Input value that selects the transition |
| wr_next | input | 3 | Next state of the transition |
| wr_out | input | 1 | Output bit of the transition |
| num_valid | input | 4 | Number of states that take part, sampled at start |
| start | input | 1 | Launches a run when not busy |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has converged |
| pass_count | output | 4 | Passes run in the current or last run |
| class_ids | output | 24 | Group label of each state, 3 bits per state |

## Verification
The embedded assertions check, on every cycle, the properties that hold at any moment:
- the table stays frozen while a run is in progress;
- the pass count stays within its bound;
- a run continues when a second start arrives;
- done and the labels hold until a new start;
- every label is the smallest member of its own group;
- excluded states report label 0.

Whether the groups themselves are right shows only in the bench's scenarios. Each scenario compares the labels and pass counts with an independent model of the refinement. The scenarios cover:
- a table in which all states are equivalent;
- a mixed table;
- an eight-pass chain;
- a reduced valid count;
- writes and restarts injected during a run.

// File: rtl/fsm_equiv_pkg.sv
package fsm_equiv_pkg;
    parameter int unsigned MAX_STATES = 8;
    localparam int unsigned IDX_W = $clog2(MAX_STATES);
    localparam int unsigned CNT_W = $clog2(MAX_STATES + 1);

    typedef logic [IDX_W-1:0] sidx_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        sidx_t nxt;
        logic  out;
    } arc_t;

    typedef struct packed {
        arc_t on1;
        arc_t on0;
    } row_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_t;

    function automatic cnt_t clamp_count(input cnt_t v);
        if (v == '0)
            return cnt_t'(1);
        else if (v > cnt_t'(MAX_STATES))
            return cnt_t'(MAX_STATES);
        else
            return v;
    endfunction
endpackage

// File: rtl/fsm_equiv_table.sv
module fsm_equiv_table
    import fsm_equiv_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_req,
    input  logic                        busy_i,
    input  sidx_t                       wr_state,
    input  logic                        wr_input,
    input  sidx_t                       wr_next,
    input  logic                        wr_out,
    output row_t [MAX_STATES-1:0]       rows_o
);
    row_t [MAX_STATES-1:0] rows_q;
    logic                  wr_take;

    assign wr_take = wr_req && !busy_i;
    assign rows_o  = rows_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rows_q <= '0;
        end else if (wr_take) begin
            if (wr_input)
                rows_q[wr_state].on1 <= '{nxt: wr_next, out: wr_out};
            else
                rows_q[wr_state].on0 <= '{nxt: wr_next, out: wr_out};
        end
    end

    AST_TABLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy_i && wr_req) |=> $stable(rows_q)); // R8
endmodule

// File: rtl/fsm_equiv_refine.sv
module fsm_equiv_refine
    import fsm_equiv_pkg::*;
(
    input  row_t  [MAX_STATES-1:0] rows_i,
    input  sidx_t [MAX_STATES-1:0] cls_cur,
    input  logic                   first_pass,
    input  cnt_t                   nvalid,
    output sidx_t [MAX_STATES-1:0] cls_nxt
);
    function automatic logic same_group(input int a, input int b,
                                        input row_t [MAX_STATES-1:0] r,
                                        input sidx_t [MAX_STATES-1:0] c,
                                        input logic by_output);
        logic keep;
        keep = (c[a] == c[b]);
        if (by_output)
            keep = keep && (r[a].on0.out == r[b].on0.out)
                        && (r[a].on1.out == r[b].on1.out);
        else
            keep = keep && (c[r[a].on0.nxt] == c[r[b].on0.nxt])
                        && (c[r[a].on1.nxt] == c[r[b].on1.nxt]);
        return keep;
    endfunction

    always_comb begin
        for (int s = 0; s < MAX_STATES; s++) begin
            cls_nxt[s] = '0;
            if (cnt_t'(s) < nvalid) begin
                for (int t = MAX_STATES - 1; t >= 0; t--) begin
                    if (t <= s && same_group(s, t, rows_i, cls_cur, first_pass))
                        cls_nxt[s] = sidx_t'(t);
                end
            end
        end
    end
endmodule

// File: rtl/fsm_equiv_ctrl.sv
module fsm_equiv_ctrl
    import fsm_equiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  cnt_t nvalid_in,
    input  logic converged,
    output logic busy,
    output logic done,
    output logic launch,
    output logic first_pass,
    output cnt_t nvalid_q,
    output cnt_t pass_cnt
);
    phase_t phase_q;

    assign busy       = (phase_q == PH_RUN);
    assign done       = (phase_q == PH_DONE);
    assign launch     = start && (phase_q != PH_RUN);
    assign first_pass = (pass_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            pass_cnt <= '0;
            nvalid_q <= cnt_t'(1);
        end else begin
            unique case (phase_q)
                PH_IDLE, PH_DONE: begin
                    if (start) begin
                        phase_q  <= PH_RUN;
                        pass_cnt <= '0;
                        nvalid_q <= clamp_count(nvalid_in);
                    end
                end
                PH_RUN: begin
                    pass_cnt <= pass_cnt + cnt_t'(1);
                    if (converged)
                        phase_q <= PH_DONE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    AST_PASS_BOUND: assert property (@(posedge clk) disable iff (rst)
        pass_cnt <= cnt_t'(MAX_STATES)); // R7
    AST_RESTART_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !converged) |=> (busy && pass_cnt == $past(pass_cnt) + cnt_t'(1))); // R9
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done); // R11
    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> !done); // R11
endmodule

// File: rtl/fsm_equiv_engine.sv
module fsm_equiv_engine
    import fsm_equiv_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_state,
    input  logic                          wr_input,
    input  logic [IDX_W-1:0]              wr_next,
    input  logic                          wr_out,
    input  logic [CNT_W-1:0]              num_valid,
    input  logic                          start,
    output logic                          busy,
    output logic                          done,
    output logic [CNT_W-1:0]              pass_count,
    output logic [MAX_STATES*IDX_W-1:0]   class_ids
);
    row_t  [MAX_STATES-1:0] rows;
    sidx_t [MAX_STATES-1:0] cls_q;
    sidx_t [MAX_STATES-1:0] cls_nxt;
    logic                   launch;
    logic                   first_pass;
    logic                   converged;
    cnt_t                   nvalid_q;

    fsm_equiv_table u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_req   (wr_en),
        .busy_i   (busy),
        .wr_state (wr_state),
        .wr_input (wr_input),
        .wr_next  (wr_next),
        .wr_out   (wr_out),
        .rows_o   (rows)
    );

    fsm_equiv_refine u_refine (
        .rows_i     (rows),
        .cls_cur    (cls_q),
        .first_pass (first_pass),
        .nvalid     (nvalid_q),
        .cls_nxt    (cls_nxt)
    );

    fsm_equiv_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .nvalid_in  (num_valid),
        .converged  (converged),
        .busy       (busy),
        .done       (done),
        .launch     (launch),
        .first_pass (first_pass),
        .nvalid_q   (nvalid_q),
        .pass_cnt   (pass_count)
    );

    assign converged = (cls_nxt == cls_q);
    assign class_ids = cls_q;

    always_ff @(posedge clk) begin
        if (rst)
            cls_q <= '0;
        else if (launch)
            cls_q <= '0;
        else if (busy)
            cls_q <= cls_nxt;
    end

    AST_LABELS_HELD: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> $stable(cls_q)); // R11

    for (genvar g = 0; g < MAX_STATES; g++) begin : g_chk
        AST_LOWEST_MEMBER: assert property (@(posedge clk) disable iff (rst)
            done |-> (cls_q[g] <= sidx_t'(g))); // R6
        AST_REP_SELF: assert property (@(posedge clk) disable iff (rst)
            done |-> (cls_q[cls_q[g]] == cls_q[g])); // R6
        AST_EXCLUDED_ZERO: assert property (@(posedge clk) disable iff (rst)
            (done && cnt_t'(g) >= nvalid_q) |-> (cls_q[g] == '0)); // R10
    end
endmodule

// File: tb/fsm_equiv_engine_tb_top.sv
module fsm_equiv_engine_tb_top;
    localparam int NS = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en, wr_input, wr_out, start;
    logic [2:0] wr_state, wr_next;
    logic [3:0] num_valid;
    logic       busy, done;
    logic [3:0] pass_count;
    logic [23:0] class_ids;

    int checks = 0;
    int fails  = 0;

    int sh_nxt [NS][2];
    int sh_out [NS][2];
    int exp_cls [NS];
    int exp_passes;
    int busy_cycles;

    always #2 clk = ~clk;

    fsm_equiv_engine dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_state(wr_state),
        .wr_input(wr_input), .wr_next(wr_next), .wr_out(wr_out),
        .num_valid(num_valid), .start(start), .busy(busy), .done(done),
        .pass_count(pass_count), .class_ids(class_ids)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int label_of(input int s);
        return int'(class_ids[s*3 +: 3]);
    endfunction

    // independent model: signature-based regrouping until stable
    task automatic model(input int nv);
        int cur [NS];
        int nw [NS];
        int sig [NS];
        bit changed;
        for (int s = 0; s < NS; s++) cur[s] = 0;
        exp_passes = 0;
        do begin
            exp_passes++;
            for (int s = 0; s < NS; s++) begin
                if (exp_passes == 1)
                    sig[s] = cur[s] * 4 + sh_out[s][0] * 2 + sh_out[s][1];
                else
                    sig[s] = cur[s] * 64 + cur[sh_nxt[s][0]] * 8 + cur[sh_nxt[s][1]];
            end
            for (int s = 0; s < NS; s++) begin
                nw[s] = 0;
                if (s < nv) begin
                    nw[s] = s;
                    for (int t = s; t >= 0; t--)
                        if (sig[t] == sig[s]) nw[s] = t;
                end
            end
            changed = 0;
            for (int s = 0; s < NS; s++) begin
                if (nw[s] != cur[s]) changed = 1;
                cur[s] = nw[s];
            end
        end while (changed && exp_passes < 20);
        for (int s = 0; s < NS; s++) exp_cls[s] = cur[s];
    endtask

    task automatic drive_row(input int s, input int x, input int n, input int z);
        wr_en = 1; wr_state = 3'(s); wr_input = x[0]; wr_next = 3'(n); wr_out = z[0];
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic write_row(input int s, input int x, input int n, input int z);
        sh_nxt[s][x] = n; sh_out[s][x] = z;
        drive_row(s, x, n, z);
    endtask

    task automatic pulse_start(input int nv);
        num_valid = 4'(nv); start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_done();
        busy_cycles = 0;
        while (busy && busy_cycles < 40) begin
            busy_cycles++;
            @(negedge clk);
        end
    endtask

    task automatic run_and_check(input string tag, input int nv);
        model(nv > NS ? NS : (nv < 1 ? 1 : nv));
        pulse_start(nv);
        check({tag, " R2 busy after start"}, int'(busy), 1);
        wait_done();
        check({tag, " R2 done"}, int'(done), 1);
        check({tag, " R2 busy low"}, int'(busy), 0);
        check({tag, " R5 pass count"}, int'(pass_count), exp_passes);
        check({tag, " R5 busy cycles"}, busy_cycles, exp_passes);
        for (int s = 0; s < NS; s++)
            check({tag, " R1 R3 R4 R6 label"}, label_of(s), exp_cls[s]);
    endtask

    task automatic t_reset();
        check("R2 reset busy", int'(busy), 0);
        check("R2 reset done", int'(done), 0);
        check("R2 reset pass_count", int'(pass_count), 0);
        check("R2 reset labels", int'(class_ids), 0);
    endtask

    task automatic t_uniform();
        for (int s = 0; s < NS; s++)
            for (int x = 0; x < 2; x++) write_row(s, x, s, 0);
        run_and_check("uniform R3", 8);
        check("R5 uniform single pass", int'(pass_count), 1);
    endtask

    task automatic t_mixed();
        int n0 [6] = '{1, 2, 0, 4, 5, 3};
        int o0 [6] = '{0, 0, 1, 0, 0, 1};
        int n1 [6] = '{3, 3, 3, 0, 0, 0};
        for (int s = 0; s < 6; s++) begin
            write_row(s, 0, n0[s], o0[s]);
            write_row(s, 1, n1[s], 0);
        end
        run_and_check("mixed R4", 6);
    endtask

    task automatic t_chain();
        for (int s = 0; s < NS; s++) begin
            write_row(s, 0, s < 7 ? s + 1 : 7, 0);
            write_row(s, 1, s < 7 ? s + 1 : 7, s == 7 ? 1 : 0);
        end
        run_and_check("chain R7", 8);
        check("R7 eight passes", int'(pass_count), 8);
        for (int s = 0; s < NS; s++) check("R4 chain all distinct", label_of(s), s);
    endtask

    task automatic t_busy_write_and_restart();
        model(8);
        pulse_start(8);
        drive_row(0, 1, 0, 1);        // R8 write during run, shadow untouched
        drive_row(7, 0, 0, 1);
        start = 1;                    // R9 restart attempt mid-run
        @(negedge clk);
        start = 0;
        busy_cycles = 3;
        while (busy && busy_cycles < 40) begin
            busy_cycles++;
            @(negedge clk);
        end
        check("R9 busy cycles unchanged", busy_cycles, exp_passes);
        check("R9 pass count unchanged", int'(pass_count), exp_passes);
        run_and_check("after busy writes R8", 8);
    endtask

    task automatic t_partial();
        write_row(0, 0, 1, 0); write_row(0, 1, 1, 0);
        write_row(1, 0, 0, 0); write_row(1, 1, 0, 0);
        write_row(2, 0, 2, 1); write_row(2, 1, 2, 0);
        run_and_check("partial R10", 3);
        for (int s = 3; s < NS; s++) check("R10 excluded label", label_of(s), 0);
        run_and_check("count zero R10", 0);
        check("R10 zero as one", int'(pass_count), 1);
        run_and_check("count high R10", 15);
    endtask

    task automatic t_hold();
        int snap;
        snap = int'(class_ids);
        repeat (5) @(negedge clk);
        check("R11 done held", int'(done), 1);
        check("R11 labels held", int'(class_ids), snap);
        pulse_start(8);
        check("R11 done cleared", int'(done), 0);
        wait_done();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst = 1; wr_en = 0; wr_input = 0; wr_out = 0; start = 0;
        wr_state = '0; wr_next = '0; num_valid = 4'd8;
        for (int s = 0; s < NS; s++)
            for (int x = 0; x < 2; x++) begin sh_nxt[s][x] = 0; sh_out[s][x] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_uniform();
        t_mixed();
        t_chain();
        t_busy_write_and_restart();
        t_partial();
        t_hold();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule